// File: doc/BRIEF.md
# Dual-Direction AES Byte Substitution Unit

This block performs the byte substitution step of AES in either direction. A single mode bit chooses between the forward substitution, used for encryption, and the inverse substitution, used for decryption. The result is purely combinational. The output follows the data and mode inputs without a clock, so the unit can be placed inside a round datapath or in a key schedule lane. When several bytes must be substituted in the same cycle, it can be replicated.

No 256-entry table is stored. The byte is first carried by a constant linear map into a three-level tower field, built as GF(2^2), then GF(2^4), then GF(2^8). A single multiplicative inverter works in that field. The result is then carried back by a second constant linear map.

The affine step of the forward direction is folded into the outgoing map together with its constant. The inverse affine step of the inverse direction is folded into the incoming map. Both directions therefore share one inverter, and the only cost of supporting both is a pair of byte-wide selectors.

The field basis is chosen at elaboration by two parameters:
- which of the eight roots of the AES reduction polynomial defines the isomorphism;
- which of the two valid constants closes the GF(2^4) extension.

Every matrix is computed from those two choices when the design is elaborated.

Top module: `aes_sbox_dual`

## Requirements
- R1: With `modeInv` = 0, `dataOut` equals the AES forward substitution of `dataIn`. That is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (with zero taken as zero), followed by the affine map bit_i ^ bit_(i+4) ^ bit_(i+5) ^ bit_(i+6) ^ bit_(i+7) (indices mod 8) and XOR with 0x63. This holds for all 256 inputs.
- R2: With `modeInv` = 1, `dataOut` equals the AES inverse substitution of `dataIn` for all 256 inputs. It is the unique byte whose forward substitution is `dataIn`.
- R3: A zero operand at the inverter yields zero. Hence the forward direction maps 0x00 to 0x63, and the inverse direction maps 0x63 to 0x00.
- R4: For every byte x, feeding the forward result of x back in with `modeInv` = 1 returns x.
- R5: In both directions, `dataOut` never equals `dataIn` and never equals the bitwise complement of `dataIn`.
- R6: The unit holds no state. A change of `dataIn` or `modeInv` alone, with no clock edge, gives the new correct `dataOut`.
- R7: The output for every input and mode does not depend on the basis parameters. `ROOT_PICK` may be any value 0 to 7, and `SUB_LAMBDA` may be 2'b10 or 2'b11, and the output is the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 8 | Byte to substitute, standard AES polynomial basis |
| modeInv | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| dataOut | output | 8 | Substituted byte, standard AES polynomial basis |

## Verification
The bench builds two copies side by side.
- The first uses the default basis: the first root of the AES polynomial, with the GF(2^4) constant set to the GF(2^2) generator.
- The second uses the sixth root with the other GF(2^4) constant.

As a result, two different sets of mapping matrices, with different inverter internals, are driven through all 512 input and mode combinations. Their outputs are compared with each other and with a table that the bench derives by brute-force inversion. This brings basis-dependent errors within reach, such as a wrong folded constant or a mis-derived inverse matrix, which a single fixed basis might mask.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;

  localparam int BYTE_W  = 8;
  localparam int HALF_W  = BYTE_W / 2;
  localparam int QUART_W = HALF_W / 2;

  typedef logic [BYTE_W-1:0]               byte_t;
  typedef logic [HALF_W-1:0]               nib_t;
  typedef logic [QUART_W-1:0]              pair_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0]   bitMat_t;   // bitMat[row][col]

  typedef struct packed {
    logic fwdPath;
    logic invPath;
  } modeStrobe_t;

  localparam byte_t AFFINE_C = 8'h63;

  // GF(2^2), modulus w^2 + w + 1
  function automatic pair_t gf4Mul(input pair_t a, input pair_t b);
    pair_t r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  // squaring doubles as inversion in GF(2^2)
  function automatic pair_t gf4Sq(input pair_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // GF(2^4) = GF(2^2)[z] / (z^2 + z + lam)
  function automatic nib_t gf16Mul(input nib_t a, input nib_t b, input pair_t lam);
    pair_t hh;
    nib_t  r;
    hh      = gf4Mul(a[3:2], b[3:2]);
    r[3:2]  = hh ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]);
    r[1:0]  = gf4Mul(hh, lam) ^ gf4Mul(a[1:0], b[1:0]);
    return r;
  endfunction

  function automatic nib_t gf16Inv(input nib_t a, input pair_t lam);
    pair_t nrm;
    pair_t nrmInv;
    nrm    = gf4Mul(gf4Sq(a[3:2]), lam) ^ gf4Mul(a[3:2], a[1:0]) ^ gf4Sq(a[1:0]);
    nrmInv = gf4Sq(nrm);
    return {gf4Mul(a[3:2], nrmInv), gf4Mul(a[3:2] ^ a[1:0], nrmInv)};
  endfunction

  // GF(2^8) = GF(2^4)[y] / (y^2 + y + mu)
  function automatic byte_t gf256Mul(input byte_t a, input byte_t b,
                                     input pair_t lam, input nib_t mu);
    nib_t  hh;
    byte_t r;
    hh     = gf16Mul(a[7:4], b[7:4], lam);
    r[7:4] = hh ^ gf16Mul(a[7:4], b[3:0], lam) ^ gf16Mul(a[3:0], b[7:4], lam);
    r[3:0] = gf16Mul(hh, mu, lam) ^ gf16Mul(a[3:0], b[3:0], lam);
    return r;
  endfunction

  // first mu for which y^2 + y + mu has no root in GF(2^4)
  function automatic nib_t findMu(input pair_t lam);
    nib_t pick;
    logic got;
    logic hit;
    pick = '0;
    got  = 1'b0;
    for (int m = 1; m < 16; m++) begin
      hit = 1'b0;
      for (int y = 0; y < 16; y++) begin
        if ((gf16Mul(nib_t'(y), nib_t'(y), lam) ^ nib_t'(y)) == nib_t'(m)) hit = 1'b1;
      end
      if (!hit && !got) begin
        pick = nib_t'(m);
        got  = 1'b1;
      end
    end
    return pick;
  endfunction

  // the pick-th root (counting from 0) of x^8+x^4+x^3+x+1 in the tower field
  function automatic byte_t findRoot(input pair_t lam, input nib_t mu, input int pick);
    byte_t res;
    byte_t b;
    byte_t b2;
    byte_t b4;
    byte_t b8;
    int    cnt;
    logic  got;
    res = '0;
    cnt = 0;
    got = 1'b0;
    for (int c = 2; c < 256; c++) begin
      b  = byte_t'(c);
      b2 = gf256Mul(b, b, lam, mu);
      b4 = gf256Mul(b2, b2, lam, mu);
      b8 = gf256Mul(b4, b4, lam, mu);
      if ((b8 ^ b4 ^ gf256Mul(b2, b, lam, mu) ^ b ^ 8'h01) == 8'h00) begin
        if (cnt == pick && !got) begin
          res = b;
          got = 1'b1;
        end
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic byte_t applyMat(input bitMat_t m, input byte_t x);
    byte_t y;
    for (int r = 0; r < BYTE_W; r++) y[r] = ^(m[r] & x);
    return y;
  endfunction

  // column c holds root^c written in the tower basis
  function automatic bitMat_t buildIso(input byte_t root, input pair_t lam, input nib_t mu);
    bitMat_t m;
    byte_t   pw;
    pw = 8'h01;
    for (int c = 0; c < BYTE_W; c++) begin
      for (int r = 0; r < BYTE_W; r++) m[r][c] = pw[r];
      pw = gf256Mul(pw, root, lam, mu);
    end
    return m;
  endfunction

  function automatic bitMat_t invertMat(input bitMat_t m);
    bitMat_t inv;
    byte_t   xb;
    byte_t   y;
    inv = '0;
    for (int x = 0; x < 256; x++) begin
      xb = byte_t'(x);
      y  = applyMat(m, xb);
      for (int j = 0; j < BYTE_W; j++) begin
        if (y == (byte_t'(1) << j)) begin
          for (int r = 0; r < BYTE_W; r++) inv[r][j] = xb[r];
        end
      end
    end
    return inv;
  endfunction

  function automatic bitMat_t matMul(input bitMat_t a, input bitMat_t b);
    bitMat_t c;
    byte_t   col;
    byte_t   res;
    for (int k = 0; k < BYTE_W; k++) begin
      for (int j = 0; j < BYTE_W; j++) col[j] = b[j][k];
      res = applyMat(a, col);
      for (int r = 0; r < BYTE_W; r++) c[r][k] = res[r];
    end
    return c;
  endfunction

  function automatic bitMat_t affineMat();
    bitMat_t m;
    m = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i][i]                = 1'b1;
      m[i][(i + 4) % BYTE_W] = 1'b1;
      m[i][(i + 5) % BYTE_W] = 1'b1;
      m[i][(i + 6) % BYTE_W] = 1'b1;
      m[i][(i + 7) % BYTE_W] = 1'b1;
    end
    return m;
  endfunction

  function automatic bitMat_t invAffineMat();
    bitMat_t m;
    m = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i][(i + 2) % BYTE_W] = 1'b1;
      m[i][(i + 5) % BYTE_W] = 1'b1;
      m[i][(i + 7) % BYTE_W] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sbox_mode_ctrl.sv
module sbox_mode_ctrl
  import sbox_tower_pkg::*;
(
  input  logic        modeInv,
  output modeStrobe_t strobes
);

  always_comb begin
    strobes.fwdPath = ~modeInv;
    strobes.invPath = modeInv;
  end

endmodule

// File: rtl/gf256_tower_inv.sv
module gf256_tower_inv
  import sbox_tower_pkg::*;
#(
  parameter logic [1:0] SUB_LAMBDA = 2'b10
) (
  input  byte_t opIn,
  output byte_t opInv
);

  localparam nib_t MU = findMu(SUB_LAMBDA);

  nib_t hiIn;
  nib_t loIn;
  nib_t normVal;
  nib_t normInv;

  assign hiIn = opIn[BYTE_W-1:HALF_W];
  assign loIn = opIn[HALF_W-1:0];

  // reduction of the operand to a subfield norm
  assign normVal = gf16Mul(gf16Mul(hiIn, hiIn, SUB_LAMBDA), MU, SUB_LAMBDA)
                 ^ gf16Mul(hiIn, loIn, SUB_LAMBDA)
                 ^ gf16Mul(loIn, loIn, SUB_LAMBDA);

  assign normInv = gf16Inv(normVal, SUB_LAMBDA);

  // rebuild the high and low halves of the inverse
  for (genvar h = 0; h < 2; h++) begin : g_half
    nib_t factor;
    assign factor = (h == 1) ? hiIn : (hiIn ^ loIn);
    assign opInv[h*HALF_W +: HALF_W] = gf16Mul(factor, normInv, SUB_LAMBDA);
  end

endmodule

// File: rtl/sbox_map_datapath.sv
module sbox_map_datapath
  import sbox_tower_pkg::*;
#(
  parameter int         ROOT_PICK  = 0,
  parameter logic [1:0] SUB_LAMBDA = 2'b10
) (
  input  byte_t       dataIn,
  input  modeStrobe_t strobes,
  input  byte_t       invOut,
  output byte_t       invIn,
  output byte_t       dataOut
);

  localparam nib_t    MU       = findMu(SUB_LAMBDA);
  localparam byte_t   ROOT     = findRoot(SUB_LAMBDA, MU, ROOT_PICK);
  localparam bitMat_t ISO      = buildIso(ROOT, SUB_LAMBDA, MU);
  localparam bitMat_t ISO_INV  = invertMat(ISO);
  localparam bitMat_t OUT_FWD  = matMul(affineMat(), ISO_INV);
  localparam bitMat_t IN_INV   = matMul(ISO, invAffineMat());
  localparam byte_t   IN_INV_C = applyMat(ISO, applyMat(invAffineMat(), AFFINE_C));

  byte_t inFwd;
  byte_t inInvLin;
  byte_t outFwdLin;
  byte_t outInv;

  for (genvar r = 0; r < BYTE_W; r++) begin : g_row
    assign inFwd[r]     = ^(ISO[r] & dataIn);
    assign inInvLin[r]  = ^(IN_INV[r] & dataIn);
    assign outFwdLin[r] = ^(OUT_FWD[r] & invOut);
    assign outInv[r]    = ^(ISO_INV[r] & invOut);
  end

  assign invIn   = ({BYTE_W{strobes.fwdPath}} & inFwd)
                 | ({BYTE_W{strobes.invPath}} & (inInvLin ^ IN_INV_C));

  assign dataOut = ({BYTE_W{strobes.fwdPath}} & (outFwdLin ^ AFFINE_C))
                 | ({BYTE_W{strobes.invPath}} & outInv);

endmodule

// File: rtl/aes_sbox_dual.sv
module aes_sbox_dual
  import sbox_tower_pkg::*;
#(
  parameter int         ROOT_PICK  = 0,
  parameter logic [1:0] SUB_LAMBDA = 2'b10
) (
  input  logic [7:0] dataIn,
  input  logic       modeInv,
  output logic [7:0] dataOut
);

  modeStrobe_t strobes;
  byte_t       invIn;
  byte_t       invOut;

  sbox_mode_ctrl ctrl_i (
    .modeInv (modeInv),
    .strobes (strobes)
  );

  sbox_map_datapath #(
    .ROOT_PICK  (ROOT_PICK),
    .SUB_LAMBDA (SUB_LAMBDA)
  ) dp_i (
    .dataIn  (dataIn),
    .strobes (strobes),
    .invOut  (invOut),
    .invIn   (invIn),
    .dataOut (dataOut)
  );

  gf256_tower_inv #(
    .SUB_LAMBDA (SUB_LAMBDA)
  ) inv_i (
    .opIn  (invIn),
    .opInv (invOut)
  );

endmodule

// File: rtl/aes_sbox_dual_chk.sv
module aes_sbox_dual_chk
  import sbox_tower_pkg::*;
#(
  parameter logic [1:0] SUB_LAMBDA = 2'b10
) (
  input logic [7:0] dataIn,
  input logic       modeInv,
  input logic [7:0] dataOut,
  input logic [7:0] invIn,
  input logic [7:0] invOut
);

  localparam nib_t MU = findMu(SUB_LAMBDA);

  always_comb begin
    // R3: zero operand stays zero through the inverter
    p_inv_zero_r3: assert ((invIn == 8'h00) == (invOut == 8'h00))
      else $error("inverter zero handling broken");
    // R1 / R2: the shared inverter produces a true tower-field inverse
    if (invIn != 8'h00) begin
      p_inv_product_r1: assert (gf256Mul(invIn, invOut, SUB_LAMBDA, MU) == 8'h01)
        else $error("inverter product is not one");
    end
    if (!modeInv && dataIn == 8'h00) begin
      p_fwd_zero_r3: assert (dataOut == 8'h63) else $error("forward zero image wrong");
    end
    if (modeInv && dataIn == 8'h63) begin
      p_inv_zero_r3b: assert (dataOut == 8'h00) else $error("inverse of 0x63 wrong");
    end
    p_no_fixed_r5: assert (dataOut != dataIn && dataOut != ~dataIn)
      else $error("fixed or opposite fixed point");
  end

endmodule

bind aes_sbox_dual aes_sbox_dual_chk #(.SUB_LAMBDA(SUB_LAMBDA)) chk_i (
  .dataIn  (dataIn),
  .modeInv (modeInv),
  .dataOut (dataOut),
  .invIn   (invIn),
  .invOut  (invOut)
);

// File: tb/aes_sbox_dual_tb_top.sv
module aes_sbox_dual_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic       modeInv = 1'b0;
  logic [7:0] dataOut;
  logic [7:0] dataOutAlt;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  logic [7:0] fwdRef [256];
  logic [7:0] invRef [256];

  always #4 clk = ~clk;   // 125 MHz

  aes_sbox_dual dut_i (
    .dataIn  (dataIn),
    .modeInv (modeInv),
    .dataOut (dataOut)
  );

  aes_sbox_dual #(.ROOT_PICK(5), .SUB_LAMBDA(2'b11)) dut_alt_i (
    .dataIn  (dataIn),
    .modeInv (modeInv),
    .dataOut (dataOutAlt)
  );

  // {mode, input, expected}
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7c}, {1'b0, 8'h53, 8'hed},
    {1'b0, 8'hff, 8'h16}, {1'b0, 8'h80, 8'hcd}, {1'b0, 8'h11, 8'h82},
    {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7c, 8'h01}, {1'b1, 8'hed, 8'h53},
    {1'b1, 8'h16, 8'hff}, {1'b1, 8'h00, 8'h52}, {1'b1, 8'hcd, 8'h80}
  };

  function automatic logic [7:0] aesMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] v);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s mode=%0d in=%02h actual=%02h expected=%02h",
               req, modeInv, dataIn, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [7:0] x);
    @(negedge clk);
    modeInv = m;
    dataIn  = x;
    #2;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // reference table by brute-force inversion
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv;
      iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (x != 0 && aesMul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      fwdRef[x] = affine(iv);
    end
    for (int x = 0; x < 256; x++) invRef[fwdRef[x]] = 8'(x);

    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check("R3 reset-state forward zero", dataOut, 8'h63);

    // vector table
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][16], VEC[i][15:8]);
      check(VEC[i][16] ? "R2 vector" : "R1 vector", dataOut, VEC[i][7:0]);
    end

    // exhaustive, both modes, both builds
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 256; x++) begin
        drive(m[0], 8'(x));
        check(m == 0 ? "R1 exhaustive" : "R2 exhaustive", dataOut,
              m == 0 ? fwdRef[x] : invRef[x]);
        check("R7 basis independence", dataOutAlt, dataOut);
        total++;
        if (dataOut == 8'(x) || dataOut == ~8'(x)) begin
          bad++;
          $display("FAIL R5 mode=%0d in=%02h actual=%02h expected=not in/~in",
                   m, x, dataOut);
        end
      end
    end

    // R4: round trip
    for (int x = 0; x < 256; x++) begin
      logic [7:0] mid;
      drive(1'b0, 8'(x));
      mid = dataOut;
      drive(1'b1, mid);
      check("R4 round trip", dataOut, 8'(x));
    end

    // R3 directed corners
    drive(1'b1, 8'h63);
    check("R3 inverse of 0x63", dataOut, 8'h00);
    drive(1'b0, 8'h00);
    check("R3 forward of 0x00", dataOutAlt, 8'h63);

    // R6: changes with no clock edge in between
    @(negedge clk);
    modeInv = 1'b0;
    dataIn  = 8'h53;
    #1;
    check("R6 data change no clock", dataOut, fwdRef[8'h53]);
    modeInv = 1'b1;
    #1;
    check("R6 mode change no clock", dataOut, invRef[8'h53]);
    dataIn = 8'hc3;
    #1;
    check("R6 second data change", dataOut, invRef[8'hc3]);

    finish();
  end

endmodule